// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the responder side of a memory-mapped command mailbox. A host processor reaches it through a simple single-cycle register bus that decodes a 256-byte window. A service controller sits on the other side. The host first loads up to four 32-bit words of outgoing payload. It then writes a command word. That write rings a doorbell toward the controller and marks the mailbox busy.

The controller reads the latched command and the payload words through its own side port. It deposits any response words into a host-readable response buffer. It then strobes completion with an error flag and an 8-bit error code. If the command asked for a completion interrupt, the host receives a single-cycle pulse that needs no clearing.

The host polls a status word. This word shows busy, error, the sub-command id of the command in flight, the id of the initiator that issued it, the error code, and a sticky flag recording a command write that was rejected because the mailbox was still busy.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the status word reads 0, and `h_irq` and `c_doorbell` are low.
- R2: A host write to offset 0x00 while not busy is accepted. From the next cycle on, `c_cmd` holds the written word, status bit 0 (busy) is 1, status bits [7:4] hold command bits [15:12], status bits [15:8] hold `h_src_id` as sampled at the write, and the error bit and error code read 0. `c_doorbell` is high for exactly that one cycle.
- R3: Busy stays set until the controller pulses `c_done`. At that strobe busy clears, status bit 1 takes `c_err` and status bits [23:16] take `c_err_code`.
- R4: A host write to offset 0x00 while busy leaves `c_cmd` unchanged and raises no doorbell. It sets status bit 2 (overrun), which stays set until reset.
- R5: When the accepted command had bit 8 set, completion produces a one-cycle `h_irq` pulse in the cycle after `c_done`. When bit 8 was clear, `h_irq` stays low.
- R6: Host writes to offset 0x80+4k (k=0..3) store word k of the payload buffer, which the controller reads on `c_wbuf_rdata` with `c_wbuf_idx`=k. Host reads of offsets 0x00 and 0x80-0x8F return 0.
- R7: A controller write with `c_rbuf_we` stores response word k, which the host reads at offset 0x90+4k. Host writes to 0x90-0x9F change nothing.
- R8: Host accesses to any other offset (for example 0x08 or 0xC0) read 0, and writes to them leave the status and buffers unchanged.
- R9: A `c_done` pulse while not busy leaves the status word unchanged and raises no `h_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 8 | Host byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_src_id | input | 8 | Id of the initiator issuing the access |
| h_rdata | output | 32 | Host read data, combinational from the address |
| h_irq | output | 1 | Completion interrupt pulse to host |
| c_doorbell | output | 1 | New-command pulse to controller |
| c_cmd | output | 32 | Latched command word |
| c_wbuf_idx | input | 2 | Payload word index for controller read |
| c_wbuf_rdata | output | 32 | Selected payload word |
| c_rbuf_we | input | 1 | Controller response-word write strobe |
| c_rbuf_idx | input | 2 | Response word index |
| c_rbuf_wdata | input | 32 | Response word data |
| c_done | input | 1 | Controller completion strobe |
| c_err | input | 1 | Error flag sampled at completion |
| c_err_code | input | 8 | Error code sampled at completion |

## Verification
Two commands are used. One has the completion-interrupt bit set and a non-zero sub-command id. The other has the bit clear and a different sub-command and initiator id. Comparing them shows that the interrupt follows bit 8 alone and that the status fields track the latest accepted command. A second command write while busy and a completion strobe while idle tell a real acceptance or completion apart from a rejected one. Distinct word patterns in every buffer slot, together with writes aimed at the response buffer, the command register and unmapped offsets, show the index mapping and which locations are write-only, read-only or absent.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  localparam int DATA_W = 32;
  localparam int ID_W   = 8;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BUF  = 8'h80;

  function automatic logic cmd_ioc(input logic [DATA_W-1:0] w);
    return w[8];
  endfunction

  function automatic logic [3:0] cmd_sub(input logic [DATA_W-1:0] w);
    return w[15:12];
  endfunction

  function automatic logic [DATA_W-1:0] status_pack(
      input logic busy, input logic err, input logic ovr,
      input logic [3:0] sub, input logic [ID_W-1:0] init,
      input logic [7:0] code);
    return {8'h00, code, init, sub, 1'b0, ovr, err, busy};
  endfunction
endpackage

// File: rtl/cmd_mailbox_decode.sv
module cmd_mailbox_decode
  import cmd_mailbox_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  localparam int IW = $clog2(BUF_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cmd,
  output logic              hit_stat,
  output logic              hit_wbuf,
  output logic              hit_rbuf,
  output logic [IW-1:0]     word_idx
);
  localparam int BUF_BYTES = 4 * BUF_WORDS;
  localparam int WB_LO = int'(OFS_BUF);
  localparam int RB_LO = WB_LO + BUF_BYTES;
  localparam int RB_HI = RB_LO + BUF_BYTES;

  int a;
  always_comb begin
    a        = int'(addr);
    hit_cmd  = (addr[ADDR_W-1:2] == OFS_CMD[ADDR_W-1:2]);
    hit_stat = (addr[ADDR_W-1:2] == OFS_STAT[ADDR_W-1:2]);
    hit_wbuf = (a >= WB_LO) && (a < RB_LO);
    hit_rbuf = (a >= RB_LO) && (a < RB_HI);
    word_idx = addr[IW+1:2];
  end

  // R8
  always_comb begin
    one_region_chk: assert ($onehot0({hit_cmd, hit_stat, hit_wbuf, hit_rbuf}));
  end
endmodule

// File: rtl/cmd_mailbox_words.sv
module cmd_mailbox_words
  import cmd_mailbox_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[g] <= '0;
      else if (we && (int'(widx) == g))       mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/cmd_mailbox_ctrl.sv
module cmd_mailbox_ctrl
  import cmd_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_word,
  input  logic [ID_W-1:0]   src_id,
  input  logic              done,
  input  logic              err_in,
  input  logic [7:0]        code_in,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] status,
  output logic              doorbell,
  output logic              irq
);
  logic            busy, err_q, ovr;
  logic [ID_W-1:0] init_q;
  logic [7:0]      code_q;
  logic            accept, finish, reject;

  assign accept = cmd_wr && !busy;
  assign reject = cmd_wr && busy;
  assign finish = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; err_q <= 1'b0; ovr <= 1'b0;
      init_q <= '0; code_q <= '0; cmd_q <= '0;
      doorbell <= 1'b0; irq <= 1'b0;
    end else begin
      doorbell <= accept;
      irq      <= finish && cmd_ioc(cmd_q);
      if (accept) begin
        busy   <= 1'b1;
        cmd_q  <= cmd_word;
        init_q <= src_id;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy   <= 1'b0;
        err_q  <= err_in;
        code_q <= code_in;
      end
      if (reject) ovr <= 1'b1;
    end
  end

  assign status = status_pack(busy, err_q, ovr, cmd_sub(cmd_q), init_q, code_q);

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && doorbell);
  // R3
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R4
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ovr && !doorbell && $stable(cmd_q));
  // R5
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && cmd_ioc(cmd_q));
  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy && !cmd_wr |=> !busy && !irq && $stable(err_q) && $stable(code_q));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int BUF_WORDS = 4,
  localparam int IW = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [ID_W-1:0]   h_src_id,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_irq,
  output logic              c_doorbell,
  output logic [DATA_W-1:0] c_cmd,
  input  logic [IW-1:0]     c_wbuf_idx,
  output logic [DATA_W-1:0] c_wbuf_rdata,
  input  logic              c_rbuf_we,
  input  logic [IW-1:0]     c_rbuf_idx,
  input  logic [DATA_W-1:0] c_rbuf_wdata,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [7:0]        c_err_code
);
  logic          hit_cmd, hit_stat, hit_wbuf, hit_rbuf;
  logic [IW-1:0] widx;
  logic [DATA_W-1:0] status, rbuf_rdata;
  logic host_wr, host_rd;

  assign host_wr = h_sel && h_we;
  assign host_rd = h_sel && !h_we;

  cmd_mailbox_decode #(.BUF_WORDS(BUF_WORDS)) u_dec (
    .addr(h_addr), .hit_cmd(hit_cmd), .hit_stat(hit_stat),
    .hit_wbuf(hit_wbuf), .hit_rbuf(hit_rbuf), .word_idx(widx)
  );

  cmd_mailbox_words #(.WORDS(BUF_WORDS)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .we(host_wr && hit_wbuf), .widx(widx),
    .wdata(h_wdata), .ridx(c_wbuf_idx), .rdata(c_wbuf_rdata)
  );

  cmd_mailbox_words #(.WORDS(BUF_WORDS)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .we(c_rbuf_we), .widx(c_rbuf_idx),
    .wdata(c_rbuf_wdata), .ridx(widx), .rdata(rbuf_rdata)
  );

  cmd_mailbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(host_wr && hit_cmd), .cmd_word(h_wdata),
    .src_id(h_src_id), .done(c_done), .err_in(c_err), .code_in(c_err_code),
    .cmd_q(c_cmd), .status(status), .doorbell(c_doorbell), .irq(h_irq)
  );

  always_comb begin
    h_rdata = '0;
    if (host_rd) begin
      if (hit_stat)      h_rdata = status;
      else if (hit_rbuf) h_rdata = rbuf_rdata;
    end
  end

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && (hit_cmd || hit_wbuf) |-> h_rdata == '0);
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  logic        clk = 0, rst_n = 0;
  logic        h_sel = 0, h_we = 0;
  logic [7:0]  h_addr = 0, h_src_id = 0;
  logic [31:0] h_wdata = 0, h_rdata, c_cmd, c_wbuf_rdata, c_rbuf_wdata = 0;
  logic        h_irq, c_doorbell, c_rbuf_we = 0, c_done = 0, c_err = 0;
  logic [1:0]  c_wbuf_idx = 0, c_rbuf_idx = 0;
  logic [7:0]  c_err_code = 0;
  int nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  cmd_mailbox u_cmd_mailbox (.*);

  function automatic logic [31:0] exp_stat(int busy, int err, int ovr, int sub, int init, int code);
    return (code << 16) + (init << 8) + (sub << 4) + (ovr << 2) + (err << 1) + busy;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [7:0] a, logic [31:0] d, logic [7:0] id);
    @(negedge clk); h_sel = 1; h_we = 1; h_addr = a; h_wdata = d; h_src_id = id;
    @(negedge clk); h_sel = 0; h_we = 0;
  endtask

  task automatic hrd(logic [7:0] a, output logic [31:0] d);
    h_sel = 1; h_we = 0; h_addr = a; #1; d = h_rdata; h_sel = 0;
  endtask

  task automatic cdone(logic e, logic [7:0] code);
    @(negedge clk); c_done = 1; c_err = e; c_err_code = code;
    @(negedge clk); c_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hrd(8'h04, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, h_irq}, 0);
    chk("R1 doorbell", {31'b0, c_doorbell}, 0);
  endtask

  task automatic t_wbuf();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) hwr(8'h80 + 8'(4*k), 32'hA0B0_0000 + 32'(k*17), 8'h01);
    for (int k = 0; k < 4; k++) begin
      c_wbuf_idx = 2'(k); #1;
      chk("R6 wbuf word", c_wbuf_rdata, 32'hA0B0_0000 + 32'(k*17));
    end
    hrd(8'h84, d); chk("R6 wbuf read zero", d, 0);
    hrd(8'h00, d); chk("R6 cmd read zero", d, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    hwr(8'h00, 32'h0008_31A5, 8'h5C);
    chk("R2 doorbell", {31'b0, c_doorbell}, 1);
    chk("R2 c_cmd", c_cmd, 32'h0008_31A5);
    hrd(8'h04, d); chk("R2 status", d, exp_stat(1, 0, 0, 3, 8'h5C, 0));
    @(negedge clk); chk("R2 doorbell pulse", {31'b0, c_doorbell}, 0);
    repeat (3) @(negedge clk);
    hrd(8'h04, d); chk("R3 busy held", d, exp_stat(1, 0, 0, 3, 8'h5C, 0));
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    hwr(8'h00, 32'h0000_7011, 8'h11);
    chk("R4 no doorbell", {31'b0, c_doorbell}, 0);
    chk("R4 c_cmd kept", c_cmd, 32'h0008_31A5);
    hrd(8'h04, d); chk("R4 overrun", d, exp_stat(1, 0, 1, 3, 8'h5C, 0));
  endtask

  task automatic t_rbuf();
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); c_rbuf_we = 1; c_rbuf_idx = 2'(k); c_rbuf_wdata = 32'h5EED_0000 + 32'(k*257);
    end
    @(negedge clk); c_rbuf_we = 0;
    for (int k = 0; k < 4; k++) begin
      hrd(8'h90 + 8'(4*k), d); chk("R7 rbuf word", d, 32'h5EED_0000 + 32'(k*257));
    end
    hwr(8'h94, 32'hDEAD_BEEF, 8'h01);
    hrd(8'h94, d); chk("R7 host write ignored", d, 32'h5EED_0101);
  endtask

  task automatic t_done_ioc();
    logic [31:0] d;
    cdone(1, 8'h3C);
    chk("R5 irq pulse", {31'b0, h_irq}, 1);
    hrd(8'h04, d); chk("R3 completion status", d, exp_stat(0, 1, 1, 3, 8'h5C, 8'h3C));
    @(negedge clk); chk("R5 irq one cycle", {31'b0, h_irq}, 0);
  endtask

  task automatic t_idle_done();
    logic [31:0] d;
    cdone(0, 8'h77);
    chk("R9 no irq", {31'b0, h_irq}, 0);
    hrd(8'h04, d); chk("R9 status kept", d, exp_stat(0, 1, 1, 3, 8'h5C, 8'h3C));
  endtask

  task automatic t_cmd_noioc();
    logic [31:0] d;
    hwr(8'h00, 32'h0004_200F, 8'h22);
    chk("R2 second doorbell", {31'b0, c_doorbell}, 1);
    hrd(8'h04, d); chk("R2 fields cleared", d, exp_stat(1, 0, 1, 2, 8'h22, 0));
    cdone(0, 8'h05);
    chk("R5 no irq without ioc", {31'b0, h_irq}, 0);
    hrd(8'h04, d); chk("R3 clean completion", d, exp_stat(0, 0, 1, 2, 8'h22, 8'h05));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    hwr(8'h08, 32'hFFFF_FFFF, 8'h09);
    hwr(8'hC0, 32'h1234_5678, 8'h09);
    hrd(8'h08, d); chk("R8 0x08 reads zero", d, 0);
    hrd(8'hC0, d); chk("R8 0xC0 reads zero", d, 0);
    hrd(8'h04, d); chk("R8 status untouched", d, exp_stat(0, 0, 1, 2, 8'h22, 8'h05));
    hrd(8'h90, d); chk("R8 rbuf untouched", d, 32'h5EED_0000);
    chk("R8 no doorbell", {31'b0, c_doorbell}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset(); t_wbuf(); t_cmd(); t_overrun(); t_rbuf();
        t_done_ioc(); t_idle_done(); t_cmd_noioc(); t_unmapped();
      end
      begin
        repeat (5000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule